// File: doc/BRIEF.md
# Translation-Unit Event Performance Monitor

This block counts hardware events raised by an address-translation unit. Four independent counters each watch one line of a 32-line event bus, chosen by a 5-bit selector in that counter's type register. A global control register gates all counting, zeroes chosen counters on demand and sets the polarity of the interrupt line. A counter that wraps past its maximum value sets a sticky overflow flag. When the flag's interrupt enable is set, that flag drives the single interrupt output.

Software programs the unit through a simple register port. It writes with `bus_wr`. Reads are combinational on `bus_addr`. Control sits at 0x00 and status at 0x04. The type registers start at 0x20 and the count registers start at 0x40, both with a 4-byte step per counter index. Any other address reads as zero.

Top module: `mmu_evmon`

## Requirements
- R1: While control bit 0 (master enable) is zero, no counter changes, except when a counter is cleared by R2.
- R2: Writing the control register with bit 8+n set zeroes counter n at that write's clock edge. A clear wins over an increment in the same cycle. Bits [11:8] are never stored and always read as zero.
- R3: Control bit 2 sets interrupt polarity. With bit 2 at one, a pending interrupt drives `irq_o` high. With bit 2 at zero, a pending interrupt drives `irq_o` low.
- R4: Status bits [3:0] are the overflow flags of counters 3..0. Writing a one to a flag clears it. Writing a zero leaves it unchanged. A wrap in the same cycle wins over the clear.
- R5: An interrupt is pending while any overflow flag is set whose counter has type bit 0 (interrupt enable) set. While no such flag is set, `irq_o` sits at the inverse of control bit 2.
- R6: A counter advances by one on each enabled cycle in which `evt_i[sel]` is high, where sel is type bits [6:2]. Only sel values 3, 4, 6, 8 and 15 count. Every other value, including 0, counts nothing.
- R7: Control reads as {bit2 polarity, bit0 enable}. Status reads as the flags in bits [3:0]. Type register n sits at 0x20+4n and reads as {sel in [6:2], enable in [0]}. Count n sits at 0x40+4n and reads zero-extended. All other bits and addresses read zero.
- R8: Each counter is CNT_W bits wide (32 by default). It wraps from all-ones to zero, and its overflow flag is set at the same clock edge.
- R9: Writes to the count registers have no effect.
- R10: After reset every register reads zero and `irq_o` is high, because no interrupt is pending and polarity is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on `bus_addr` |
| evt_i | input | 32 | Event lines, one per event type |
| irq_o | output | 1 | Overflow interrupt, programmable polarity |

## Verification
Read data depends on `bus_addr` without a register in between. A register write, a clear, an increment or a wrap therefore shows up in the read data and in `irq_o` one clock after the cycle that caused it. The interrupt level follows the flags and polarity in the same cycle they change. The bench drives every input at the falling edge and lets combinational paths settle for 1 ns. It then compares read data and the interrupt against a behavioural model, which updates on the rising edge from the same inputs. Every check thus samples exactly one edge after its stimulus.

// File: rtl/mmu_evmon_pkg.sv
package mmu_evmon_pkg;
  localparam int unsigned SEL_W = 5;
  localparam int unsigned EVT_W = 1 << SEL_W;
  localparam logic [7:0] CTRL_ADDR = 8'h00;
  localparam logic [7:0] STAT_ADDR = 8'h04;
  localparam logic [7:0] TYPE_BASE = 8'h20;
  localparam logic [7:0] CNT_BASE  = 8'h40;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_POL_BIT = 2;
  localparam int unsigned CTRL_CLR_LSB = 8;

  // Event codes with a defined meaning; all others are inert.
  function automatic logic sel_is_live(input logic [SEL_W-1:0] sel);
    case (sel)
      5'd3, 5'd4, 5'd6, 5'd8, 5'd15: sel_is_live = 1'b1;
      default:                       sel_is_live = 1'b0;
    endcase
  endfunction

  // Byte address of slot idx in an array starting at base.
  function automatic logic [7:0] slot_addr(input logic [7:0] base, input int unsigned idx);
    slot_addr = base + 8'(idx * 4);
  endfunction

  function automatic logic irq_level(input logic pending, input logic active_high);
    irq_level = active_high ? pending : ~pending;
  endfunction
endpackage

// File: rtl/mmu_evmon_counter.sv
module mmu_evmon_counter
  import mmu_evmon_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic [EVT_W-1:0] evt,
  output logic [CNT_W-1:0] cnt,
  output logic             step,
  output logic             wrap
);
  assign step = run & sel_is_live(sel) & evt[sel];
  assign wrap = step & ~clr & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mmu_evmon_irq.sv
module mmu_evmon_irq
  import mmu_evmon_pkg::*;
#(
  parameter int unsigned NCNT = 4
) (
  input  logic [NCNT-1:0] flags,
  input  logic [NCNT-1:0] ie,
  input  logic            pol,
  output logic            pending,
  output logic            irq
);
  assign pending = |(flags & ie);
  assign irq     = irq_level(pending, pol);
endmodule

// File: rtl/mmu_evmon.sv
module mmu_evmon
  import mmu_evmon_pkg::*;
#(
  parameter int unsigned NCNT   = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_W-1:0]  evt_i,
  output logic              irq_o
);
  localparam int unsigned SEL_LSB = 2;

  logic                   ctrl_en, ctrl_pol;
  logic [NCNT-1:0]        flags, ie, clr, step, wrap, w1c;
  logic [SEL_W-1:0]       sel   [NCNT];
  logic [CNT_W-1:0]       cnt   [NCNT];
  logic [NCNT*CNT_W-1:0]  cnt_flat;
  logic                   wr_ctrl, wr_stat, pending;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_pol <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_en  <= bus_wdata[CTRL_EN_BIT];
      ctrl_pol <= bus_wdata[CTRL_POL_BIT];
    end
  end

  for (genvar n = 0; n < NCNT; n++) begin : g_slot
    localparam logic [ADDR_W-1:0] TYPE_A = ADDR_W'(slot_addr(TYPE_BASE, n));
    logic wr_type;
    assign wr_type = bus_wr && (bus_addr == TYPE_A);
    assign clr[n]  = wr_ctrl && bus_wdata[CTRL_CLR_LSB + n];
    assign w1c[n]  = wr_stat && bus_wdata[n];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel[n] <= '0;
        ie[n]  <= 1'b0;
      end else if (wr_type) begin
        sel[n] <= bus_wdata[SEL_LSB +: SEL_W];
        ie[n]  <= bus_wdata[0];
      end
    end

    mmu_evmon_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (ctrl_en),
      .clr  (clr[n]),
      .sel  (sel[n]),
      .evt  (evt_i),
      .cnt  (cnt[n]),
      .step (step[n]),
      .wrap (wrap[n])
    );
    assign cnt_flat[n*CNT_W +: CNT_W] = cnt[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~w1c) | wrap;
  end

  mmu_evmon_irq #(.NCNT(NCNT)) u_irq (
    .flags  (flags),
    .ie     (ie),
    .pol    (ctrl_pol),
    .pending(pending),
    .irq    (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
      bus_rdata[CTRL_EN_BIT]  = ctrl_en;
      bus_rdata[CTRL_POL_BIT] = ctrl_pol;
    end else if (bus_addr == ADDR_W'(STAT_ADDR)) begin
      bus_rdata[NCNT-1:0] = flags;
    end
    for (int n = 0; n < NCNT; n++) begin
      if (bus_addr == ADDR_W'(slot_addr(TYPE_BASE, n))) begin
        bus_rdata[SEL_LSB +: SEL_W] = sel[n];
        bus_rdata[0]                = ie[n];
      end
      if (bus_addr == ADDR_W'(slot_addr(CNT_BASE, n)))
        bus_rdata[CNT_W-1:0] = cnt[n];
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata, pending};
endmodule

// File: rtl/mmu_evmon_chk.sv
module mmu_evmon_chk #(
  parameter int unsigned NCNT  = 4,
  parameter int unsigned CNT_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ctrl_en,
  input logic                  ctrl_pol,
  input logic [NCNT-1:0]       step,
  input logic [NCNT-1:0]       wrap,
  input logic [NCNT-1:0]       clr,
  input logic [NCNT-1:0]       w1c,
  input logic [NCNT-1:0]       flags,
  input logic [NCNT-1:0]       ie,
  input logic [NCNT*CNT_W-1:0] cnt_flat,
  input logic                  irq_o
);
  for (genvar n = 0; n < NCNT; n++) begin : g_chk
    a_r1_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |-> !step[n]);
    a_r2_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr[n] |=> (cnt_flat[n*CNT_W +: CNT_W] == '0));
    a_r8_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[n] |=> (flags[n] && cnt_flat[n*CNT_W +: CNT_W] == '0));
    a_r4_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (w1c[n] && !wrap[n]) |=> !flags[n]);
  end
  a_r5_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ie) == '0) |-> (irq_o == !ctrl_pol));
  a_r3_irq_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ie) != '0) |-> (irq_o == ctrl_pol));
endmodule

bind mmu_evmon mmu_evmon_chk #(.NCNT(NCNT), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_en (ctrl_en),
  .ctrl_pol(ctrl_pol),
  .step    (step),
  .wrap    (wrap),
  .clr     (clr),
  .w1c     (w1c),
  .flags   (flags),
  .ie      (ie),
  .cnt_flat(cnt_flat),
  .irq_o   (irq_o)
);

// File: tb/tb_mmu_evmon.sv
`timescale 1ns/1ps
module tb_mmu_evmon;
  localparam int CW = 8;
  localparam int NC = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        b_wr = 0;
  logic [7:0]  b_addr = 0;
  logic [31:0] b_wdata = 0;
  logic [31:0] b_rdata;
  logic [31:0] evt = 0;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mmu_evmon #(.NCNT(NC), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(b_rdata), .evt_i(evt), .irq_o(irq)
  );

  // behavioural reference
  int m_cnt[NC];
  int m_sel[NC];
  bit m_ie[NC];
  bit m_flag[NC];
  bit m_en, m_pol;

  function automatic bit live(int s);
    return (s == 3) || (s == 4) || (s == 6) || (s == 8) || (s == 15);
  endfunction

  function automatic int mread(int a);
    int v = 0;
    if (a == 0) v = (m_pol ? 4 : 0) + (m_en ? 1 : 0);
    else if (a == 4) begin
      for (int i = 0; i < NC; i++) if (m_flag[i]) v += (1 << i);
    end
    for (int i = 0; i < NC; i++) begin
      if (a == 32 + 4*i) v = m_sel[i]*4 + (m_ie[i] ? 1 : 0);
      if (a == 64 + 4*i) v = m_cnt[i];
    end
    return v;
  endfunction

  function automatic bit mirq();
    bit p = 0;
    for (int i = 0; i < NC; i++) if (m_flag[i] && m_ie[i]) p = 1;
    return m_pol ? p : !p;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        m_cnt[i] = 0; m_sel[i] = 0; m_ie[i] = 0; m_flag[i] = 0;
      end
      m_en = 0; m_pol = 0;
    end else begin
      for (int i = 0; i < NC; i++) begin
        bit zap, inc, wrapped;
        zap = b_wr && b_addr == 0 && b_wdata[8+i];
        inc = m_en && live(m_sel[i]) && evt[m_sel[i]];
        wrapped = 0;
        if (zap) m_cnt[i] = 0;
        else if (inc) begin
          if (m_cnt[i] == (1 << CW) - 1) begin m_cnt[i] = 0; wrapped = 1; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
        if (wrapped) m_flag[i] = 1;
        else if (b_wr && b_addr == 4 && b_wdata[i]) m_flag[i] = 0;
        if (b_wr && b_addr == 8'(32 + 4*i)) begin
          m_sel[i] = int'(b_wdata[6:2]); m_ie[i] = b_wdata[0];
        end
      end
      if (b_wr && b_addr == 0) begin m_en = b_wdata[0]; m_pol = b_wdata[2]; end
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", tag, b_addr, act, exp);
    end
  endtask

  // one bus cycle: drive at falling edge, compare after settling
  task automatic cyc(string tag, bit wr, int a, int d, logic [31:0] e);
    @(negedge clk);
    b_wr = wr; b_addr = 8'(a); b_wdata = d; evt = e;
    #1;
    if (!wr) check(tag, int'(b_rdata), mread(a));
    check({tag, "-irq"}, int'(irq), int'(mirq()));
  endtask

  task automatic rd(string tag, int a);
    cyc(tag, 0, a, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state, fixed expectations
    @(negedge clk); #1;
    check("R10", int'(irq), 1);
    b_addr = 8'h00; #1; check("R10", int'(b_rdata), 0);
    b_addr = 8'h04; #1; check("R10", int'(b_rdata), 0);
    b_addr = 8'h40; #1; check("R10", int'(b_rdata), 0);
    for (int i = 0; i < NC; i++) begin rd("R10", 32+4*i); rd("R10", 64+4*i); end

    // R1: disabled, events present
    cyc("R1", 1, 32, 3<<2, 0);
    for (int k = 0; k < 5; k++) cyc("R1", 0, 64, 0, 32'hFFFF_FFFF);
    rd("R1", 64);
    @(negedge clk); #1; b_addr = 8'h40; #1; check("R1", int'(b_rdata), 0);

    // R6: defined selectors
    cyc("R6", 1, 36, 4<<2, 0);
    cyc("R6", 1, 40, (6<<2)|1, 0);
    cyc("R6", 1, 44, 8<<2, 0);
    cyc("R6", 1, 0, 1, 0);
    for (int k = 0; k < 4; k++) cyc("R6", 0, 64, 0, 32'h0000_0008);
    for (int k = 0; k < 3; k++) cyc("R6", 0, 68, 0, 32'h0000_0050);
    for (int k = 0; k < 2; k++) cyc("R6", 0, 72, 0, 32'h0000_0100);
    for (int i = 0; i < NC; i++) rd("R6", 64+4*i);
    @(negedge clk); b_wr = 0; evt = 0; b_addr = 8'h40; #1; check("R6", int'(b_rdata), 4);
    // R6: inert selectors 5, 0, 31; then 15
    cyc("R6", 1, 36, 5<<2, 0);
    cyc("R6", 1, 40, 0, 0);
    cyc("R6", 1, 44, 31<<2, 0);
    for (int k = 0; k < 5; k++) cyc("R6", 0, 68, 0, 32'hFFFF_FFFF);
    for (int i = 1; i < NC; i++) rd("R6", 64+4*i);
    cyc("R6", 1, 44, 15<<2, 0);
    for (int k = 0; k < 3; k++) cyc("R6", 0, 76, 0, 32'h0000_8000);
    rd("R6", 76);

    // R2: clear counter 0 while enabled, reset bits not stored
    cyc("R2", 1, 0, 1 | (1<<8), 32'h0000_0008);
    rd("R2", 0);
    rd("R2", 64);
    @(negedge clk); #1; b_addr = 8'h40; #1; check("R2", int'(b_rdata), 0);

    // R9: count registers ignore writes
    cyc("R9", 1, 76, 32'h55, 0);
    rd("R9", 76);

    // R8 / R5: wrap counter 0 with interrupt enable, low polarity
    cyc("R8", 1, 32, (3<<2)|1, 0);
    for (int k = 0; k < 260; k++) cyc("R8", 0, (k % 2) ? 4 : 64, 0, 32'h0000_0008);
    rd("R8", 4);
    @(negedge clk); #1; b_addr = 8'h04; #1; check("R8", int'(b_rdata[0]), 1);
    check("R5", int'(irq), 0);

    // R3: switch polarity high
    cyc("R3", 1, 0, 5, 0);
    rd("R3", 4);
    @(negedge clk); #1; check("R3", int'(irq), 1);

    // R4: zero write leaves flag, one write clears it
    cyc("R4", 1, 4, 0, 0);
    rd("R4", 4);
    cyc("R4", 1, 4, 1, 0);
    rd("R4", 4);
    @(negedge clk); #1; b_addr = 8'h04; #1; check("R4", int'(b_rdata), 0);
    check("R5", int'(irq), 0);

    // R7: random traffic with full model comparison
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 15);
      int addrs[8] = '{0, 4, 32, 36, 40, 44, 64, 72};
      int ra = addrs[$urandom_range(0, 7)];
      if (r == 0)      cyc("R7", 1, 0, int'($urandom) & 32'h0F05, $urandom);
      else if (r == 1) cyc("R7", 1, 4, $urandom, $urandom);
      else if (r == 2) cyc("R7", 1, 32 + 4*$urandom_range(0, 3),
                           ($urandom_range(0, 15) < 10 ? 4*(3 + $urandom_range(0, 1)) : 4*$urandom_range(0, 31)) | $urandom_range(0, 1), $urandom);
      else             cyc("R7", 0, (k % 3 == 0) ? ra : 64 + 4*(k % 4), 0, $urandom);
    end
    rd("R7", 8'h10);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule